// File: doc/BRIEF.md
# Two-Level Nanocoded Control Sequencer

This block is the control unit of a microprogrammed processor. Its control store is split into two levels. A narrow microcode ROM holds only sequencing information. A wide nanoinstruction ROM holds each distinct control pattern exactly once. Every microword is one of two kinds. A jump word steers the micro-PC, either always or when a chosen condition flag is set. A pointer word names one nanoinstruction. That nanoinstruction is then expanded into the full set of datapath control lines.

A macroinstruction starts when a one-cycle dispatch pulse arrives together with its opcode. The pulse loads the micro-PC from a small table indexed by the opcode. From then on the routine runs by itself, one microword per clock. Both ROMs are read synchronously. The microcode ROM is addressed with the next micro-PC, so its output always belongs to the current micro-PC. The nanoinstruction read then adds one cycle. As a result, the control lines for a micro-PC value appear one cycle after that value.

Top module: `nanoseq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `upc` becomes 0 and every bit of `ctrl` is 0 after that edge. Reset takes priority over dispatch.
- R2: After a pointer microword (bit 16 = 0, pointer in bits 8:0), `upc` advances by one on the next edge. It wraps from 1023 to 0.
- R3: A jump microword (bit 16 = 1) whose condition select (bits 12:10) is 0 always loads `upc` with its target (bits 9:0).
- R4: A jump microword with condition select k in 1..4 loads the target when `flags[k-1]` is 1. When that flag is 0, the word acts like a pointer and `upc` advances by one.
- R5: A `dispatch` pulse loads `upc` from the opcode table. This overrides what the current microword would do to the sequence. The table sends opcode k to 64+8k, except opcode 15, which goes to 1022.
- R6: The `ctrl` value seen after a clock edge is produced by the microword at the `upc` value held before that edge.
- R7: In the cycle after a jump microword, `ctrl` is all zeros, whether or not the jump is taken.
- R8: The 68-bit nanoword is decoded as follows.
  - Bits 5:0 drive `ctrl[5:0]` directly.
  - Eight 4-bit fields start at bit 6. A nonzero value v in field i sets only `ctrl[6+15i+v-1]`.
  - Ten 3-bit fields start at bit 38. A nonzero value v in field j sets only `ctrl[126+7j+v-1]`.
  - A zero field sets no line.
- R9: Microwords in different routines that point at the same nanoinstruction entry give identical `ctrl` patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dispatch | input | 1 | One-cycle pulse that starts a macroinstruction |
| opcode | input | 4 | Macroinstruction opcode, used only while `dispatch` is high |
| flags | input | 4 | Condition flags tested by conditional jump words |
| ctrl | output | 196 | Decoded datapath control lines |
| upc | output | 10 | Current micro-PC |

## Verification
The bench goes after three groups of corner cases.

The first group is sequencing priority.
- A dispatch that arrives in the middle of a routine must win over a pending jump. A design that ignored it would run on into the old routine.
- A dispatch held together with reset must leave `upc` at 0. A design with the priorities reversed would land in the routine instead.

The second group is the condition path. Each opcode's routine is run twice, with the flags complemented between the two runs, so every flag select is seen both taken and not taken. A design with a misindexed flag or an inverted test would follow the wrong branch in one of the two runs.

The third group covers wrap-around, gating and decoding.
- The opcode 15 routine walks past address 1023. A design with a bad increment would fail to wrap to 0.
- Control lines must be blanked after every jump word. A design that let the stale nanoword through would show nonzero `ctrl` there.
- The same nanoinstruction entry must decode the same way from every routine that uses it. An off-by-one in the field decode would shift lines between neighbouring fields.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Default geometry of the two control stores
  localparam int UADDR_W  = 10;
  localparam int NPTR_W   = 9;
  localparam int UWORD_W  = 17;
  localparam int COND_W   = 3;
  localparam int OPC_W    = 4;
  localparam int NFLAG    = 4;

  // Nanoword layout: direct lines, then wide fields, then narrow fields
  localparam int DIRECT_W = 6;
  localparam int FA_W     = 4;
  localparam int NA       = 8;
  localparam int FB_W     = 3;
  localparam int NB       = 10;
  localparam int NANO_W   = DIRECT_W + NA * FA_W + NB * FB_W;
  localparam int CTRL_W   = DIRECT_W + NA * ((1 << FA_W) - 1) + NB * ((1 << FB_W) - 1);

  localparam int RT_BASE  = 64;
  localparam int RT_SPAN  = 8;
  localparam int HI_ENTRY = 1022;

  function automatic logic [UWORD_W-1:0] mk_ptr(input int p);
    logic [UWORD_W-1:0] w;
    w = '0;
    w[NPTR_W-1:0] = NPTR_W'(p);
    return w;
  endfunction

  function automatic logic [UWORD_W-1:0] mk_jump(input int sel, input int tgt);
    logic [UWORD_W-1:0] w;
    w = '0;
    w[UWORD_W-1] = 1'b1;
    w[UADDR_W +: COND_W] = COND_W'(sel);
    w[UADDR_W-1:0] = UADDR_W'(tgt);
    return w;
  endfunction

  // Microprogram image: idle loop at 0, one routine per opcode, tail at the top
  function automatic logic [UWORD_W-1:0] urom_init(input int a);
    int k;
    int o;
    int b;
    k = 0;
    o = 0;
    b = 0;
    if (a == 0) return mk_ptr(1);
    if (a == 1) return mk_ptr(2);
    if (a == 2) return mk_jump(0, 0);
    if (a == HI_ENTRY) return mk_ptr(7);
    if (a == HI_ENTRY + 1) return mk_ptr(8);
    if (a >= RT_BASE && a < RT_BASE + RT_SPAN * (1 << OPC_W)) begin
      k = (a - RT_BASE) / RT_SPAN;
      o = (a - RT_BASE) % RT_SPAN;
      b = RT_BASE + RT_SPAN * k;
      case (o)
        0:       return mk_ptr(3);
        1:       return mk_ptr(10 + k);
        2:       return mk_jump(k % (NFLAG + 1), b + 5);
        3:       return mk_ptr(30 + k);
        4:       return mk_jump(0, 0);
        5:       return mk_ptr(50 + k);
        6:       return mk_jump(0, 0);
        default: return mk_ptr(0);
      endcase
    end
    return mk_ptr(0);
  endfunction

  // Nanoinstruction image: entry 0 is all-inactive, others are spread patterns
  function automatic logic [NANO_W-1:0] nrom_init(input int i);
    logic [NANO_W-1:0] n;
    n = '0;
    if (i != 0) begin
      for (int j = 0; j < NANO_W; j++) n[j] = (((i * 29 + j * 13) % 11) < 4);
    end
    return n;
  endfunction

  function automatic logic [UADDR_W-1:0] disp_init(input int k);
    if (k == (1 << OPC_W) - 1) return UADDR_W'(HI_ENTRY);
    return UADDR_W'(RT_BASE + RT_SPAN * k);
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int AW   = 10,
  parameter int DW   = 17,
  parameter int KIND = 0   // 0: microcode image, 1: nanoinstruction image
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] dout
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  generate
    if (KIND == 0) begin : g_micro
      initial begin
        for (int a = 0; a < DEPTH; a++) mem[a] = DW'(urom_init(a));
      end
    end else begin : g_nano
      initial begin
        for (int a = 0; a < DEPTH; a++) mem[a] = DW'(nrom_init(a));
      end
    end
  endgenerate

  // Synchronous read, no reset: maps onto block RAM
  always_ff @(posedge clk) dout <= mem[addr];

endmodule

// File: rtl/useq_disp.sv
module useq_disp
  import useq_pkg::*;
#(
  parameter int OW = 4,
  parameter int AW = 10
) (
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] target
);

  localparam int N = 1 << OW;

  logic [AW-1:0] tbl [N];

  generate
    for (genvar k = 0; k < N; k++) begin : g_ent
      assign tbl[k] = AW'(disp_init(k));
    end
  endgenerate

  assign target = tbl[opcode];

endmodule

// File: rtl/useq_ndec.sv
module useq_ndec #(
  parameter int DIRECT_W = 6,
  parameter int FA_W     = 4,
  parameter int NA       = 8,
  parameter int FB_W     = 3,
  parameter int NB       = 10,
  localparam int LA      = (1 << FA_W) - 1,
  localparam int LB      = (1 << FB_W) - 1,
  localparam int NANO_W  = DIRECT_W + NA * FA_W + NB * FB_W,
  localparam int CTRL_W  = DIRECT_W + NA * LA + NB * LB
) (
  input  logic [NANO_W-1:0] nano,
  output logic [CTRL_W-1:0] lines
);

  localparam int B_SRC  = DIRECT_W + NA * FA_W;
  localparam int B_LINE = DIRECT_W + NA * LA;

  assign lines[DIRECT_W-1:0] = nano[DIRECT_W-1:0];

  generate
    for (genvar i = 0; i < NA; i++) begin : g_fa
      logic [FA_W-1:0] fv;
      assign fv = nano[DIRECT_W + i * FA_W +: FA_W];
      for (genvar v = 1; v <= LA; v++) begin : g_line
        assign lines[DIRECT_W + i * LA + v - 1] = (fv == FA_W'(v));
      end
    end
    for (genvar j = 0; j < NB; j++) begin : g_fb
      logic [FB_W-1:0] fv;
      assign fv = nano[B_SRC + j * FB_W +: FB_W];
      for (genvar v = 1; v <= LB; v++) begin : g_line
        assign lines[B_LINE + j * LB + v - 1] = (fv == FB_W'(v));
      end
    end
  endgenerate

endmodule

// File: rtl/nanoseq_ctrl.sv
module nanoseq_ctrl
  import useq_pkg::*;
#(
  parameter int UADDR_W  = useq_pkg::UADDR_W,
  parameter int NPTR_W   = useq_pkg::NPTR_W,
  parameter int UWORD_W  = useq_pkg::UWORD_W,
  parameter int COND_W   = useq_pkg::COND_W,
  parameter int OPC_W    = useq_pkg::OPC_W,
  parameter int NFLAG    = useq_pkg::NFLAG,
  parameter int DIRECT_W = useq_pkg::DIRECT_W,
  parameter int FA_W     = useq_pkg::FA_W,
  parameter int NA       = useq_pkg::NA,
  parameter int FB_W     = useq_pkg::FB_W,
  parameter int NB       = useq_pkg::NB,
  localparam int NANO_W  = DIRECT_W + NA * FA_W + NB * FB_W,
  localparam int CTRL_W  = DIRECT_W + NA * ((1 << FA_W) - 1) + NB * ((1 << FB_W) - 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dispatch,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [NFLAG-1:0]   flags,
  output logic [CTRL_W-1:0]  ctrl,
  output logic [UADDR_W-1:0] upc
);

  localparam int KIND_BIT = UWORD_W - 1;

  logic [UWORD_W-1:0] uword_q;   // microword at the current upc
  logic [UADDR_W-1:0] upc_next;
  logic [UADDR_W-1:0] disp_tgt;
  logic [NANO_W-1:0]  nano_q;
  logic [CTRL_W-1:0]  dec_lines;
  logic               issue_q;   // previous microword was a pointer word
  logic               is_jump;
  logic               cond_ok;
  logic [COND_W-1:0]  sel;
  logic               spare_unused;

  assign is_jump      = uword_q[KIND_BIT];
  assign sel          = uword_q[UADDR_W +: COND_W];
  assign spare_unused = ^uword_q[UWORD_W-2:UADDR_W+COND_W];

  useq_disp #(.OW(OPC_W), .AW(UADDR_W)) u_disp (
    .opcode (opcode),
    .target (disp_tgt)
  );

  always_comb begin
    cond_ok = (sel == '0);
    for (int f = 0; f < NFLAG; f++) begin
      if (int'(sel) == f + 1) cond_ok = flags[f];
    end
  end

  // Next micro-PC: reset, then dispatch, then taken jump, else increment
  always_comb begin
    if (rst)                     upc_next = '0;
    else if (dispatch)           upc_next = disp_tgt;
    else if (is_jump && cond_ok) upc_next = uword_q[UADDR_W-1:0];
    else                         upc_next = upc + UADDR_W'(1);
  end

  always_ff @(posedge clk) upc <= upc_next;

  // Read-ahead on upc_next keeps uword_q aligned with upc
  useq_rom #(.AW(UADDR_W), .DW(UWORD_W), .KIND(0)) u_mrom (
    .clk  (clk),
    .addr (upc_next),
    .dout (uword_q)
  );

  useq_rom #(.AW(NPTR_W), .DW(NANO_W), .KIND(1)) u_nrom (
    .clk  (clk),
    .addr (uword_q[NPTR_W-1:0]),
    .dout (nano_q)
  );

  always_ff @(posedge clk) begin
    if (rst) issue_q <= 1'b0;
    else     issue_q <= ~is_jump;
  end

  useq_ndec #(
    .DIRECT_W (DIRECT_W), .FA_W (FA_W), .NA (NA), .FB_W (FB_W), .NB (NB)
  ) u_ndec (
    .nano  (nano_q),
    .lines (dec_lines)
  );

  assign ctrl = issue_q ? dec_lines : '0;

  // R1: reset leaves micro-PC at 0 and the control lines quiet
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (upc == '0 && ctrl == '0));

  // R2: a pointer word advances the micro-PC by one
  assert_ptr_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dispatch) && !$past(is_jump))
      |-> (upc == $past(upc) + UADDR_W'(1)));

  // R3: an unconditional jump lands on its target
  assert_jump_target_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dispatch) && $past(is_jump) && $past(sel) == '0)
      |-> (upc == $past(uword_q[UADDR_W-1:0])));

  // R4: a conditional jump either lands on its target or falls through
  assert_cond_path_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dispatch) && $past(is_jump))
      |-> (upc == $past(uword_q[UADDR_W-1:0]) || upc == $past(upc) + UADDR_W'(1)));

  // R5: dispatch loads the opcode table entry
  assert_dispatch_load_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dispatch)) |-> (upc == $past(disp_tgt)));

  // R7: a jump word issues no control lines
  assert_jump_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_jump)) |-> (ctrl == '0));

endmodule

// File: tb/nanoseq_ctrl_bench.sv
module nanoseq_ctrl_bench;
  import useq_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               dispatch = 1'b0;
  logic [OPC_W-1:0]   opcode = '0;
  logic [NFLAG-1:0]   flags = '0;
  logic [CTRL_W-1:0]  ctrl;
  logic [UADDR_W-1:0] upc;

  always #(CLK_PERIOD/2) clk = ~clk;

  nanoseq_ctrl u_nanoseq_ctrl (
    .clk      (clk),
    .rst      (rst),
    .dispatch (dispatch),
    .opcode   (opcode),
    .flags    (flags),
    .ctrl     (ctrl),
    .upc      (upc)
  );

  // Scoreboard queues (parallel)
  logic [UADDR_W-1:0] q_upc[$];
  logic [CTRL_W-1:0]  q_ctrl[$];
  string              q_utag[$];
  string              q_ctag[$];
  int                 q_nidx[$];

  int total = 0;
  int bad = 0;
  logic [UADDR_W-1:0] m_upc = '0;
  logic [CTRL_W-1:0]  shared_seen = '0;
  bit                 shared_have = 1'b0;

  // Expected decode per R8
  function automatic logic [CTRL_W-1:0] ref_decode(input logic [NANO_W-1:0] n);
    logic [CTRL_W-1:0] c;
    int v;
    c = '0;
    for (int d = 0; d < DIRECT_W; d++) c[d] = n[d];
    for (int i = 0; i < NA; i++) begin
      v = int'(n[DIRECT_W + i*FA_W +: FA_W]);
      if (v != 0) c[DIRECT_W + i*15 + v - 1] = 1'b1;
    end
    for (int j = 0; j < NB; j++) begin
      v = int'(n[DIRECT_W + NA*FA_W + j*FB_W +: FB_W]);
      if (v != 0) c[DIRECT_W + NA*15 + j*7 + v - 1] = 1'b1;
    end
    return c;
  endfunction

  task automatic step(input bit r, input bit d, input int opc, input int fl);
    logic [UWORD_W-1:0] w;
    logic [UADDR_W-1:0] nu;
    int sel;
    bit take;
    string ut;
    @(negedge clk);
    rst = r;
    dispatch = d;
    opcode = OPC_W'(opc);
    flags = NFLAG'(fl);
    w = urom_init(int'(m_upc));
    sel = int'(w[12:10]);
    take = (sel == 0) || (sel >= 1 && sel <= NFLAG && flags[sel-1]);
    if (r)                begin nu = '0;                ut = "R1"; end
    else if (d)           begin nu = disp_init(opc);    ut = "R5"; end
    else if (w[16] && take) begin nu = w[9:0];          ut = (sel == 0) ? "R3" : "R4"; end
    else                  begin nu = m_upc + 10'd1;     ut = w[16] ? "R4" : "R2"; end
    q_upc.push_back(nu);
    q_utag.push_back(ut);
    if (r) begin
      q_ctrl.push_back('0); q_ctag.push_back("R1"); q_nidx.push_back(-1);
    end else if (w[16]) begin
      q_ctrl.push_back('0); q_ctag.push_back("R7"); q_nidx.push_back(-1);
    end else begin
      q_ctrl.push_back(ref_decode(nrom_init(int'(w[8:0]))));
      q_ctag.push_back("R6/R8");
      q_nidx.push_back(int'(w[8:0]));
    end
    m_upc = nu;
  endtask

  // Monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      logic [UADDR_W-1:0] eu;
      logic [CTRL_W-1:0]  ec;
      string ut;
      string ct;
      int ni;
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q_upc.size() > 0) begin
        eu = q_upc.pop_front();
        ec = q_ctrl.pop_front();
        ut = q_utag.pop_front();
        ct = q_ctag.pop_front();
        ni = q_nidx.pop_front();
        total++;
        if (upc !== eu) begin
          bad++;
          $display("FAIL %s upc actual=%0d expected=%0d", ut, upc, eu);
        end
        total++;
        if (ctrl !== ec) begin
          bad++;
          $display("FAIL %s ctrl actual=%h expected=%h", ct, ctrl, ec);
        end
        if (ni == 3) begin
          // R9: shared entry yields the same pattern in every routine
          if (!shared_have) begin
            shared_seen = ctrl;
            shared_have = 1'b1;
          end else begin
            total++;
            if (ctrl !== shared_seen) begin
              bad++;
              $display("FAIL R9 shared ctrl actual=%h expected=%h", ctrl, shared_seen);
            end
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int fl;
    repeat (3) step(1'b1, 1'b0, 0, 0);          // R1 reset
    repeat (8) step(1'b0, 1'b0, 0, 0);          // idle loop, R3 jump
    for (int pass = 0; pass < 2; pass++) begin
      for (int opc = 0; opc < 16; opc++) begin
        fl = (opc * 5 + 9) & 15;
        if (pass == 1) fl = fl ^ 15;            // R4 both outcomes
        step(1'b0, 1'b1, opc, fl);              // R5 dispatch
        repeat (9) step(1'b0, 1'b0, 0, fl);     // R2 wrap via opcode 15
      end
    end
    step(1'b0, 1'b1, 3, 0);                     // R5 mid-routine override
    step(1'b0, 1'b0, 0, 0);
    step(1'b0, 1'b0, 0, 0);
    step(1'b0, 1'b1, 5, 0);
    repeat (4) step(1'b0, 1'b0, 0, 0);
    step(1'b0, 1'b1, 9, 15);
    step(1'b1, 1'b1, 7, 0);                     // R1 beats dispatch
    step(1'b0, 1'b1, 2, 0);
    step(1'b0, 1'b1, 4, 15);                    // back-to-back dispatch
    repeat (8) step(1'b0, 1'b0, 0, 15);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule